// File: doc/BRIEF.md
# Processor Reset Sequence Generator

This block sits on the master clock of an attached processor and produces the two reset lines that processor expects: a cold reset, which fully initialises it, and a warm reset, which only raises a reset exception. It also drives a clock-mode strap bus that the processor reads while cold reset is asserted. When the board power-good signal rises, the block runs the power-on sequence. Cold reset is held for a long, parameterised interval. Cold reset is then released while warm reset stays low for a short interval. After that, warm reset is released and a done flag rises.

After power-up, a one-cycle request pulse can start a new full cold sequence or a warm-only (software) reset, in which cold reset stays high. The mode strap is captured once, shortly after power becomes valid. It is held frozen until power is lost, so it is settled long before cold reset is released and never moves while the processor runs. Every output comes from a flop on the master clock. When power-good falls, all flops reset at once, whether or not the clock is running.

Top module: `proc_reset_seq`

## Requirements
- R1: Cold reset (`cold_rst_n`, active low) stays low for COLD_CYCLES clock edges, counted from the first edge after the power-good synchronizer releases. On the power-up path, the bench sees this as COLD_CYCLES + SYNC_STAGES - 1 sampled cycles after `pwr_good` rises. On the request path, it sees exactly COLD_CYCLES cycles counted from the edge that takes the request.
- R2: On a cold sequence, warm reset (`warm_rst_n`, active low) is low whenever cold reset is low. Warm reset is released exactly WARM_CYCLES edges after cold reset is released.
- R3: A `req_warm` pulse taken while the block is done starts a warm-only sequence. Cold reset stays high, and warm reset is low for exactly WARM_CYCLES cycles.
- R4: `mode_strap` shows MODE_RESET while power-good is low or not yet synchronised. It takes the value of `mode_in` at the first edge after synchronizer release. It then stays unchanged until power-good falls, whatever `mode_in` or the requests do.
- R5: Requests are sampled on rising edges. When `req_cold` and `req_warm` are both high in the same cycle, the cold request wins.
- R6: While `pwr_good` is low, both resets are low, `seq_done` is low and `mode_strap` equals MODE_RESET. A fall of `pwr_good` forces this state without waiting for a clock edge.
- R7: `seq_done` rises one edge after warm reset is released. It falls at the edge that starts any new sequence, and it is never high while either reset is low.
- R8: A `req_warm` pulse during a cold sequence, or during a warm-only sequence, is ignored. Neither output duration changes.
- R9: A `req_cold` pulse during a warm-only sequence aborts it and starts a full cold sequence at that edge.
- R10: A `req_cold` pulse during a cold sequence restarts the cold interval from zero at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pwr_good | input | 1 | Power valid, asynchronous, low forces reset |
| req_cold | input | 1 | One-cycle request for a full cold sequence |
| req_warm | input | 1 | One-cycle request for a warm-only reset |
| mode_in | input | MODE_W | Clock-mode strap source, captured once |
| cold_rst_n | output | 1 | Cold reset to processor, active low |
| warm_rst_n | output | 1 | Warm reset to processor, active low |
| mode_strap | output | MODE_W | Frozen clock-mode strap |
| seq_done | output | 1 | Sequence complete |

## Verification
A request takes effect at the first rising edge that samples it, and both reset lines change at that same edge. Each interval then lasts a fixed number of edges: COLD_CYCLES for cold, WARM_CYCLES after cold release for warm, and one more edge for `seq_done`. A power-up adds SYNC_STAGES - 1 cycles before cold counting begins. The bench drives and samples only on falling edges, and it counts the sampled cycles in which each line is low. It compares those counts with totals computed from the parameters. For requests injected part-way through a sequence, the expected totals add the injection offset.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic [1:0] {
    ST_COLD = 2'd0,   // cold and warm both asserted
    ST_HOLD = 2'd1,   // cold released, warm still asserted
    ST_SOFT = 2'd2,   // warm-only reset
    ST_DONE = 2'd3    // both released
  } rsg_state_t;

  function automatic int rsg_cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/rsg_pg_sync.sv
module rsg_pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pwr_good,
  output logic rst_n
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge pwr_good)
          if (!pwr_good) chain[g] <= 1'b0;
          else           chain[g] <= 1'b1;
      end else begin : g_next
        always_ff @(posedge clk or negedge pwr_good)
          if (!pwr_good) chain[g] <= 1'b0;
          else           chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign rst_n = chain[STAGES-1];

  // R6: the released reset only rises once the stage ahead of it is high
  p_sync_order_r6: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(rst_n) |-> chain[0]);
endmodule

// File: rtl/rsg_interval_cnt.sv
module rsg_interval_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] last,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (!hit) cnt <= cnt + 1'b1;

  assign hit = (cnt == last);

  // R10: a clear always restarts the interval from zero
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/rsg_strap_hold.sv
module rsg_strap_hold #(
  parameter int          W         = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic frozen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q      <= RESET_VAL;
      frozen <= 1'b0;
    end else if (!frozen) begin
      q      <= d;
      frozen <= 1'b1;
    end

  // R4: once captured, the strap never moves while power stays valid
  p_strap_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(q));
endmodule

// File: rtl/proc_reset_seq.sv
module proc_reset_seq
  import rsg_pkg::*;
#(
  parameter int          COLD_CYCLES = 64000,
  parameter int          WARM_CYCLES = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          MODE_W      = 2,
  parameter logic [MODE_W-1:0] MODE_RESET = '0
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              req_cold,
  input  logic              req_warm,
  input  logic [MODE_W-1:0] mode_in,
  output logic              cold_rst_n,
  output logic              warm_rst_n,
  output logic [MODE_W-1:0] mode_strap,
  output logic              seq_done
);
  localparam int CW = rsg_cnt_width(COLD_CYCLES, WARM_CYCLES);
  localparam logic [CW-1:0] COLD_LAST = CW'(COLD_CYCLES - 1);
  localparam logic [CW-1:0] WARM_LAST = CW'(WARM_CYCLES - 1);

  logic       rst_n;
  logic       hit, clr;
  logic [CW-1:0] last;
  rsg_state_t state, nxt;

  rsg_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pwr_good(pwr_good), .rst_n(rst_n));

  assign last = (state == ST_COLD) ? COLD_LAST : WARM_LAST;

  rsg_interval_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .last(last), .hit(hit));

  rsg_strap_hold #(.W(MODE_W), .RESET_VAL(MODE_RESET)) u_strap (
    .clk(clk), .rst_n(rst_n), .d(mode_in), .q(mode_strap));

  // Sequencing: cold request always wins and restarts; warm request only from done
  always_comb begin
    nxt = state;
    clr = 1'b0;
    unique case (state)
      ST_COLD: begin
        if (req_cold)  clr = 1'b1;
        else if (hit) begin nxt = ST_HOLD; clr = 1'b1; end
      end
      ST_HOLD, ST_SOFT: begin
        if (req_cold)  begin nxt = ST_COLD; clr = 1'b1; end
        else if (hit)  begin nxt = ST_DONE; clr = 1'b1; end
      end
      ST_DONE: begin
        if (req_cold)      begin nxt = ST_COLD; clr = 1'b1; end
        else if (req_warm) begin nxt = ST_SOFT; clr = 1'b1; end
      end
      default: begin nxt = ST_COLD; clr = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_COLD;
      cold_rst_n <= 1'b0;
      warm_rst_n <= 1'b0;
      seq_done   <= 1'b0;
    end else begin
      state      <= nxt;
      cold_rst_n <= (nxt != ST_COLD);
      warm_rst_n <= (nxt == ST_DONE);
      seq_done   <= (state == ST_DONE) && (nxt == ST_DONE);
    end

  // ---- checker counters: run lengths of the reset lines ----
  logic [CW:0] cold_run, warm_after;
  localparam logic [CW:0] RUN_MAX = '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cold_run   <= '0;
      warm_after <= '0;
    end else begin
      if (!cold_rst_n) cold_run <= (cold_run == RUN_MAX) ? cold_run : cold_run + 1'b1;
      else             cold_run <= '0;
      if (!cold_rst_n || warm_rst_n) warm_after <= '0;
      else warm_after <= (warm_after == RUN_MAX) ? warm_after : warm_after + 1'b1;
    end

  p_cold_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cold_rst_n) |-> (cold_run >= (CW+1)'(COLD_CYCLES)));

  p_warm_covers_cold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cold_rst_n |-> !warm_rst_n);

  p_warm_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm_rst_n) |-> (warm_after >= (CW+1)'(WARM_CYCLES)));

  p_soft_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && req_warm && !req_cold) |=> (cold_rst_n && !warm_rst_n));

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (cold_rst_n && warm_rst_n));

  p_done_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(warm_rst_n));

  p_cold_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_cold |=> !cold_rst_n);
endmodule

// File: tb/sim_proc_reset_seq.sv
module sim_proc_reset_seq;
  localparam int COLD = 40;
  localparam int WARM = 5;
  localparam int SYNC = 2;
  localparam int MW   = 3;
  localparam int PUP  = COLD + SYNC - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic pwr_good = 1'b0, req_cold = 1'b0, req_warm = 1'b0;
  logic [MW-1:0] mode_in = '0;
  logic cold_rst_n, warm_rst_n, seq_done;
  logic [MW-1:0] mode_strap;

  proc_reset_seq #(.COLD_CYCLES(COLD), .WARM_CYCLES(WARM), .SYNC_STAGES(SYNC),
                   .MODE_W(MW), .MODE_RESET('0)) u0 (
    .clk(clk), .pwr_good(pwr_good), .req_cold(req_cold), .req_warm(req_warm),
    .mode_in(mode_in), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .mode_strap(mode_strap), .seq_done(seq_done));

  int n_run = 0, n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // op: 4 = power cycle, else bit0 = cold request, bit1 = warm request
  task automatic run_seq(input int op, input int mode, input int inj_at, input int inj_op,
                         output int c_lo, output int w_lo, output int gap, output int d1);
    c_lo = 0; w_lo = 0; gap = 0; d1 = 0;
    @(negedge clk);
    if (op == 4) begin
      pwr_good = 1'b0;
      repeat (3) @(negedge clk);
      mode_in  = MW'(mode);
      pwr_good = 1'b1;
    end else begin
      mode_in  = MW'(mode);
      req_cold = op[0];
      req_warm = op[1];
    end
    for (int i = 1; i <= 4000; i++) begin
      @(negedge clk);
      req_cold = 1'b0;
      req_warm = 1'b0;
      if (i == inj_at) begin
        req_cold = inj_op[0];
        req_warm = inj_op[1];
      end
      if (i == 1) d1 = int'(seq_done);
      if (!cold_rst_n) c_lo++;
      if (!warm_rst_n) w_lo++;
      else if (!seq_done) gap++;
      if (seq_done) break;
    end
  endtask

  localparam int NV = 7;
  localparam int T_OP    [NV] = '{4, 2, 1, 2, 4, 3, 1};
  localparam int T_MODE  [NV] = '{5, 2, 7, 0, 3, 6, 1};
  localparam int T_EXP_C [NV] = '{PUP, 0, COLD, 0, PUP, COLD, COLD};
  localparam int T_EXP_W [NV] = '{PUP+WARM, WARM, COLD+WARM, WARM, PUP+WARM, COLD+WARM, COLD+WARM};

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c, w, g, d, strap_exp;
    strap_exp = 0;
    // R6: reset state while power is not valid
    repeat (3) @(negedge clk);
    check("R6 cold low in power-off", int'(cold_rst_n), 0);
    check("R6 warm low in power-off", int'(warm_rst_n), 0);
    check("R6 done low in power-off", int'(seq_done), 0);
    check("R6 strap reset value", int'(mode_strap), 0);

    // Table walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      run_seq(T_OP[v], T_MODE[v], 0, 0, c, w, g, d);
      if (T_OP[v] == 4) strap_exp = T_MODE[v];
      check($sformatf("R1 R5 cold low cycles row %0d", v), c, T_EXP_C[v]);
      check($sformatf("R2 R3 warm low cycles row %0d", v), w, T_EXP_W[v]);
      check($sformatf("R7 done gap row %0d", v), g, 1);
      check($sformatf("R7 done low at start row %0d", v), d, 0);
      check($sformatf("R4 strap frozen row %0d", v), int'(mode_strap), strap_exp);
    end

    // R8: warm request in cold phase, hold phase, and warm-only sequence
    run_seq(1, 0, 10, 2, c, w, g, d);
    check("R8 warm ignored in cold phase (cold)", c, COLD);
    check("R8 warm ignored in cold phase (warm)", w, COLD + WARM);
    run_seq(1, 0, COLD + 2, 2, c, w, g, d);
    check("R8 warm ignored in hold phase", w, COLD + WARM);
    run_seq(2, 0, 2, 2, c, w, g, d);
    check("R8 warm ignored in soft seq (cold)", c, 0);
    check("R8 warm ignored in soft seq (warm)", w, WARM);

    // R9: cold request aborts a warm-only sequence
    run_seq(2, 0, 2, 1, c, w, g, d);
    check("R9 abort cold low", c, COLD);
    check("R9 abort warm low", w, COLD + WARM + 2);

    // R10: cold request during cold phase restarts interval
    run_seq(1, 0, 10, 1, c, w, g, d);
    check("R10 restart cold low", c, COLD + 10);
    check("R10 restart warm low", w, COLD + 10 + WARM);
    check("R4 strap after restarts", int'(mode_strap), strap_exp);

    // R6: power loss forces reset without a clock edge
    @(posedge clk);
    #2 pwr_good = 1'b0;
    #1;
    check("R6 async cold on power loss", int'(cold_rst_n), 0);
    check("R6 async warm on power loss", int'(warm_rst_n), 0);
    check("R6 async done on power loss", int'(seq_done), 0);
    check("R6 strap reset on power loss", int'(mode_strap), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule